// File: doc/BRIEF.md
# PHY Start-up Sync Sequencer

This block generates the pulse sequence that brings an interface PHY into a known state. Software writes one 32-bit control word through a single-register write/read port. Setting the top bit of that word launches a fixed-order run with four phases:

1. a sync-enable pulse,
2. a quiet gap,
3. a sync-reset pulse,
4. a settling wait.

A fixed tail of eight clock cycles follows the four phases. Four 4-bit fields in the same word set the phase lengths in clock cycles.

The start bit is owned by hardware while a run is in progress. It reads back as 1 until the last tail cycle has passed, and then it returns to 0. Software polls this bit to learn that the PHY is ready. The word also holds two plain mode bits: a slow/bypass flag and an SDIO flag. These bits are stored and read back and do nothing else in this block.

At the moment of launch, the block captures the four lengths into its own copy. Software may rewrite the configuration during a run without disturbing that run.

Top module: `phyinit_seq`

## Requirements
- R1: A write with bit 31 set while the block is idle launches a run. `busy_o` and read bit 31 are 1 from the clock after that write until the run ends. After the run they are 0.
- R2: `sync_en_o` is high for exactly the number of cycles in bits 11:8. It starts in the first cycle after the launching write.
- R3: After the sync-enable phase, both pulse outputs stay low for the number of cycles in bits 7:4.
- R4: After that gap, `sync_rst_o` is high for exactly the number of cycles in bits 3:0.
- R5: After the sync-reset phase, the block waits for the number of cycles in bits 15:12 and then 8 more cycles. A run therefore lasts the sum of the four fields plus 8 cycles.
- R6: A field value of 0 removes its phase completely. An all-zero configuration gives a run of exactly 8 cycles with no pulses.
- R7: Bits 29 and 28 are ordinary read/write bits, and a write with bit 31 clear never starts a run. Reads return bits 29, 28 and 15:0 as last written, bit 31 as the busy state, and 0 in every other bit.
- R8: A write with bit 31 set during a run does not restart it or change its timing.
- R9: A write during a run updates the stored bits 29, 28 and 15:0. The run in progress keeps the lengths it captured at launch.
- R10: While `rst_n` is low at a clock edge, the stored word becomes 0, any run is abandoned, and both pulse outputs are low after that edge.
- R11: `sync_en_o` and `sync_rst_o` are never high in the same cycle. Neither one is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word; bit 31 shows the run state |
| sync_en_o | output | 1 | Sync-enable pulse to the PHY |
| sync_rst_o | output | 1 | Sync-reset pulse to the PHY |
| busy_o | output | 1 | High while a run is in progress |

## Verification
The assertions assume three things about the inputs:

- `wr_en` is a clean one-cycle strobe that is sampled only at clock edges.
- `wr_data` is meaningful only when `wr_en` is high.
- Reset is held for at least one edge before normal operation.

The stimulus drives every input on the falling edge, and it pulses `wr_en` for a single cycle per write. Reset is asserted only at the start and once in the middle of a run. The random configurations are masked to the defined bits, except where the bench deliberately sets undefined bits to show that they read as 0. Writes made during a run are placed strictly before its last cycle, so that a restart attempt can never line up with the cycle in which the block goes idle.

// File: rtl/phyinit_pkg.sv
package phyinit_pkg;

    // Bit positions the software interface depends on
    localparam int START_BIT = 31;
    localparam int SLOW_BIT  = 29;
    localparam int SDIO_BIT  = 28;

    // Number of programmable phases, in run order: enable, gap, reset, settle
    localparam int NUM_PH = 4;

    // Step index encodings; the tail step follows the programmable phases
    localparam logic [2:0] STEP_EN     = 3'd0;
    localparam logic [2:0] STEP_GAP    = 3'd1;
    localparam logic [2:0] STEP_RST    = 3'd2;
    localparam logic [2:0] STEP_SETTLE = 3'd3;
    localparam logic [2:0] STEP_TAIL   = 3'd4;

    // Register field slot used by each run-order phase (field slot f covers bits 4f+3:4f)
    function automatic int field_of_step(input int step);
        case (step)
            0:       return 2;
            1:       return 1;
            2:       return 0;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/phyinit_regfile.sv
module phyinit_regfile
    import phyinit_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      busy_i,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_PH*FIELD_W-1:0] fields_o,
    output logic                      start_o
);
    localparam int FLD_TOT = NUM_PH * FIELD_W;

    typedef struct packed {
        logic               slow;
        logic               sdio;
        logic [FLD_TOT-1:0] fld;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wr_bits;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.slow = wr_data[SLOW_BIT];
            cfg_d.sdio = wr_data[SDIO_BIT];
            cfg_d.fld  = wr_data[FLD_TOT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data                = '0;
        rd_data[START_BIT]     = busy_i;
        rd_data[SLOW_BIT]      = cfg_q.slow;
        rd_data[SDIO_BIT]      = cfg_q.sdio;
        rd_data[FLD_TOT-1:0]   = cfg_q.fld;
    end

    // A launch request is honoured only from idle
    assign start_o        = wr_en && wr_data[START_BIT] && !busy_i;
    assign fields_o       = cfg_d.fld;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:FLD_TOT]};

endmodule

// File: rtl/phyinit_step_pick.sv
module phyinit_step_pick
    import phyinit_pkg::*;
#(
    parameter int FIELD_W     = 4,
    parameter int TAIL_CYCLES = 8,
    parameter int CNT_W       = 4
) (
    input  logic [2:0]                from_i,
    input  logic [NUM_PH*FIELD_W-1:0] durs_i,
    output logic [2:0]                step_o,
    output logic [CNT_W-1:0]          len_o
);
    logic [NUM_PH-1:0] nz;
    logic [FIELD_W-1:0] sel;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_nz
        assign nz[g] = |durs_i[g*FIELD_W +: FIELD_W];
    end

    // Lowest non-empty phase at or after from_i, else the fixed tail
    always_comb begin
        step_o = STEP_TAIL;
        for (int j = NUM_PH - 1; j >= 0; j--) begin
            if (nz[j] && (3'(j) >= from_i)) step_o = 3'(j);
        end
    end

    always_comb begin
        sel = '0;
        for (int j = 0; j < NUM_PH; j++) begin
            if (step_o == 3'(j)) sel = durs_i[j*FIELD_W +: FIELD_W];
        end
        if (step_o == STEP_TAIL) len_o = CNT_W'(TAIL_CYCLES);
        else                     len_o = CNT_W'(sel);
    end

endmodule

// File: rtl/phyinit_engine.sv
module phyinit_engine
    import phyinit_pkg::*;
#(
    parameter int FIELD_W     = 4,
    parameter int TAIL_CYCLES = 8,
    parameter int CNT_W       = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_PH*FIELD_W-1:0] seq_durs_i,
    output logic                      busy_o,
    output logic                      sync_en_o,
    output logic                      sync_rst_o
);
    localparam int DUR_TOT = NUM_PH * FIELD_W;

    typedef struct packed {
        logic               active;
        logic [2:0]         step;
        logic [CNT_W-1:0]   cnt;
        logic [DUR_TOT-1:0] durs;
    } eng_t;

    eng_t st_d, st_q;

    logic [2:0]       first_step, next_step;
    logic [CNT_W-1:0] first_len,  next_len;

    // First phase chosen from the freshly captured lengths
    phyinit_step_pick #(
        .FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES), .CNT_W(CNT_W)
    ) u_pick_first (
        .from_i (3'd0),
        .durs_i (seq_durs_i),
        .step_o (first_step),
        .len_o  (first_len)
    );

    // Following phase chosen from the held lengths
    phyinit_step_pick #(
        .FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES), .CNT_W(CNT_W)
    ) u_pick_next (
        .from_i (st_q.step + 3'd1),
        .durs_i (st_q.durs),
        .step_o (next_step),
        .len_o  (next_len)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.durs   = seq_durs_i;
                st_d.step   = first_step;
                st_d.cnt    = first_len - CNT_W'(1);
            end
        end else if (st_q.cnt == '0) begin
            if (st_q.step == STEP_TAIL) begin
                st_d.active = 1'b0;
                st_d.step   = '0;
            end else begin
                st_d.step = next_step;
                st_d.cnt  = next_len - CNT_W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.active;
    assign sync_en_o  = st_q.active && (st_q.step == STEP_EN);
    assign sync_rst_o = st_q.active && (st_q.step == STEP_RST);

endmodule

// File: rtl/phyinit_seq.sv
module phyinit_seq
    import phyinit_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FIELD_W     = 4,
    parameter int TAIL_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_en_o,
    output logic              sync_rst_o,
    output logic              busy_o
);
    localparam int TAIL_W = $clog2(TAIL_CYCLES + 1);
    localparam int CNT_W  = (FIELD_W > TAIL_W) ? FIELD_W : TAIL_W;
    localparam int DUR_TOT = NUM_PH * FIELD_W;

    logic [DUR_TOT-1:0] fields;
    logic [DUR_TOT-1:0] seq_durs;
    logic               start;

    phyinit_regfile #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .busy_i   (busy_o),
        .rd_data  (rd_data),
        .fields_o (fields),
        .start_o  (start)
    );

    // Reorder register slots into run order
    for (genvar g = 0; g < NUM_PH; g++) begin : g_order
        assign seq_durs[g*FIELD_W +: FIELD_W] =
            fields[field_of_step(g)*FIELD_W +: FIELD_W];
    end

    phyinit_engine #(
        .FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES), .CNT_W(CNT_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .seq_durs_i (seq_durs),
        .busy_o     (busy_o),
        .sync_en_o  (sync_en_o),
        .sync_rst_o (sync_rst_o)
    );

endmodule

// File: rtl/phyinit_seq_chk.sv
module phyinit_seq_chk #(
    parameter int DATA_W      = 32,
    parameter int TAIL_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              sync_en_o,
    input logic              sync_rst_o,
    input logic              busy_o
);
    // Cycles since the last pulse, saturating
    logic [7:0] quiet_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                      quiet_q <= '0;
        else if (sync_en_o || sync_rst_o) quiet_q <= '0;
        else if (quiet_q != 8'hFF)       quiet_q <= quiet_q + 8'd1;
    end

    a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && wr_en && wr_data[31]) |=> (busy_o && rd_data[31]));

    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] == busy_o);

    a_r5_tail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && $past(rst_n)) |-> (quiet_q >= 8'(TAIL_CYCLES)));

    a_r7_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(wr_en && wr_data[31])) |=> !busy_o);

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !sync_en_o && !sync_rst_o && rd_data == '0));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_en_o && sync_rst_o));

    a_r11_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en_o || sync_rst_o) |-> busy_o);

endmodule

bind phyinit_seq phyinit_seq_chk #(.DATA_W(DATA_W), .TAIL_CYCLES(TAIL_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .sync_en_o  (sync_en_o),
    .sync_rst_o (sync_rst_o),
    .busy_o     (busy_o)
);

// File: tb/phyinit_seq_test.sv
module phyinit_seq_test;
    localparam logic [31:0] RW_MASK = 32'h3000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sync_en_o, sync_rst_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] shadow = '0;

    always #5 clk = ~clk;

    phyinit_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sync_en_o(sync_en_o), .sync_rst_o(sync_rst_o),
        .busy_o(busy_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int run_len(input logic [31:0] c);
        return int'(c[11:8]) + int'(c[7:4]) + int'(c[3:0]) + int'(c[15:12]) + 8;
    endfunction

    function automatic logic exp_en(input logic [31:0] c, input int i);
        return i < int'(c[11:8]);
    endfunction

    function automatic logic exp_rst(input logic [31:0] c, input int i);
        int a = int'(c[11:8]) + int'(c[7:4]);
        return (i >= a) && (i < a + int'(c[3:0]));
    endfunction

    // Launch a run with cfg; optionally write mid_data after cycle mid_at
    task automatic run_seq(input logic [31:0] cfg, input int mid_at,
                           input logic [31:0] mid_data, input string tag);
        int total = run_len(cfg);
        int gap_lo = int'(cfg[11:8]);
        int gap_hi = gap_lo + int'(cfg[7:4]);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = cfg | 32'h8000_0000;
        shadow = cfg & RW_MASK;
        for (int i = 0; i <= total; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (i < total) begin
                chk("R1", {31'd0, rd_data[31]}, 32'd1);
                chk("R2", {31'd0, sync_en_o}, {31'd0, exp_en(cfg, i)});
                chk("R4", {31'd0, sync_rst_o}, {31'd0, exp_rst(cfg, i)});
                chk("R11", {31'd0, sync_en_o & sync_rst_o}, 32'd0);
                if (i >= gap_lo && i < gap_hi)
                    chk("R3", {30'd0, sync_en_o, sync_rst_o}, 32'd0);
                chk(tag, {31'd0, busy_o}, 32'd1);
            end else begin
                chk(tag, {31'd0, busy_o}, 32'd0);
                chk(tag, rd_data, shadow);
            end
            if (i == mid_at) begin
                wr_en = 1'b1;
                wr_data = mid_data;
                shadow = mid_data & RW_MASK;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", rd_data, 32'd0);
        chk("R10", {29'd0, busy_o, sync_en_o, sync_rst_o}, 32'd0);
        rst_n = 1'b1;

        // R7: mode bits and undefined bits, no launch
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h7F0F_A5C3;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7", rd_data, 32'h3000_A5C3);
        chk("R7", {31'd0, busy_o}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7", {30'd0, busy_o, sync_en_o}, 32'd0);

        // Directed shapes
        run_seq(32'h0000_0000, -1, '0, "R6");
        run_seq(32'h0000_1234, -1, '0, "R5");
        run_seq(32'h2000_F0F0, -1, '0, "R6");
        run_seq(32'h1000_0F0F, -1, '0, "R6");
        run_seq(32'h3000_FFFF, -1, '0, "R5");
        // R8: restart attempt mid-run, same config
        run_seq(32'h0000_2222, 3, 32'h8000_2222, "R8");
        // R9: new lengths written mid-run, old run unaffected
        run_seq(32'h0000_3131, 2, 32'h9000_0001, "R9");
        // Next run uses the stored new lengths
        run_seq(shadow, -1, '0, "R9");

        // Random runs
        for (int k = 0; k < 24; k++) begin
            logic [31:0] cfg = $urandom() & RW_MASK;
            logic [31:0] mid = $urandom();
            int t = run_len(cfg);
            int m = (k % 3 == 0) ? int'($urandom_range(0, t - 2)) : -1;
            run_seq(cfg, m, mid, (m >= 0) ? "R9" : "R5");
        end

        // R10: reset in the middle of a run
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h8000_3333;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", rd_data, 32'd0);
        chk("R10", {29'd0, busy_o, sync_en_o, sync_rst_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", {31'd0, busy_o}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule